// File: doc/BRIEF.md
# Interrupt Controller with Keyboard Wake

This block combines the system interrupt logic of a small 8-bit processor bus with the reading of an 8x8 keyboard matrix. Software programs an interrupt-enable register, reads a status register and writes an acknowledge register through a simple port interface addressed by the low address byte. The block drives one registered, level-sensitive interrupt line back to the processor.

A keyboard read uses the upper address byte as eight active-low row selects. Each selected row's active-low column bits are ANDed into the returned byte. If keyboard-wait is enabled, the same read also puts the controller into a snooze state, and a `snooze` output tells the surrounding system to hold the processor. While snoozing, the controller looks at the whole matrix on every 5 ms tick. The first tick that finds any key down brings it back to awake and latches a key flag in the status register.

Top module: `irq_kbd_wake`

## Requirements
- R1: The `irq` output is never high unless enable bit 0 (global enable) was set in the previous clock.
- R2: With the global enable set, `irq` goes high one clock after (enable AND status AND 0xFC) becomes nonzero, or after status bit 0 and enable bit 1 are both set. Otherwise it goes low one clock after the condition ends.
- R3: A write to the acknowledge port (low address 0x41) masks the written byte with 0x6C (bits 6, 5, 3, 2) and clears those bits in the enable register. If bit 2 survives the mask, the key flag is also cleared. A write to port 0x40 loads the enable register.
- R4: A read of port 0x40 returns the status byte. The same read clears the status bit 1 latch, unless a new `evt_pulse` arrives in that same clock.
- R5: A read of port 0x42 returns 0xFF ANDed with every row r (bits 8r+7..8r of `key_rows`) whose select address bit 8+r is 0. Row 7 is selected by A15 and row 0 by A8.
- R6: A keyboard read made while enable bit 7 (keyboard wait) is set raises `snooze` on the next clock.
- R7: While snoozing, a clock with `tick_5ms` high and any bit of `key_rows` at 0 clears `snooze` on the next clock and sets the key flag (status bit 2).
- R8: While snoozing, the controller stays in snooze if a tick comes with no key down, or if a key is down with no tick.
- R9: After reset the enable register, the bit 1 latch, the key flag, `irq` and `snooze` are all 0.
- R10: Status bit 0 is `rtc_flag`, bit 1 is the event latch, bit 2 is the key flag, and bits 7..3 follow `evt_lvl[4:0]`. Reads of any other port return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Port write strobe |
| bus_rd | input | 1 | Port read strobe |
| bus_addr | input | 16 | Port address; low byte selects the port, high byte holds row selects |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| key_rows | input | 64 | Active-low key matrix, row r in bits 8r+7..8r |
| tick_5ms | input | 1 | One-clock pulse every 5 ms |
| rtc_flag | input | 1 | Real-time-clock interrupt flag (status bit 0) |
| evt_pulse | input | 1 | Sets the status bit 1 latch |
| evt_lvl | input | 5 | Level sources for status bits 7..3 |
| irq | output | 1 | Registered interrupt request |
| snooze | output | 1 | High while the controller is in snooze |

## Verification
The hardest case to reach is the wake from snooze. It needs a keyboard read with keyboard wait enabled, followed by the rare combination of a tick together with a key held down. Plain random stimulus seldom lines these up, so directed sequences enter snooze and then try tick-only and key-only clocks before the combined one. Random traffic weights a few key presses and ticks on top of this. A per-clock reference model checks `irq`, `snooze` and every read across all of these clocks.

// File: rtl/irq_kbd_pkg.sv
package irq_kbd_pkg;
  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam logic [7:0] MASKABLE_ACK = 8'h6C;
  localparam logic [7:0] NON_TIMER    = 8'hFC;
  localparam int GIE_BIT   = 0;
  localparam int TMR_EN    = 1;
  localparam int TMR_STA   = 0;
  localparam int KEY_STA   = 2;
  localparam int KWAIT_BIT = 7;

  // Interrupt request condition from enable and status bytes.
  function automatic logic irq_wanted(input logic [7:0] en, input logic [7:0] sta);
    logic others, timer;
    others = |(en & sta & NON_TIMER);
    timer  = en[TMR_EN] & sta[TMR_STA];
    return en[GIE_BIT] & (others | timer);
  endfunction
endpackage

// File: rtl/kbd_matrix.sv
module kbd_matrix #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic [ROWS*COLS-1:0] rows_n,
  input  logic [ROWS-1:0]      sel_n,
  output logic [COLS-1:0]      data,
  output logic                 any_down
);
  logic [COLS-1:0] stage [ROWS+1];
  assign stage[0] = '1;
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign stage[r+1] = sel_n[r] ? stage[r] : (stage[r] & rows_n[r*COLS +: COLS]);
  end
  assign data     = stage[ROWS];
  assign any_down = ~&rows_n;
endmodule

// File: rtl/snooze_ctl.sv
module snooze_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic tick,
  input  logic any_down,
  output logic snooze_o,
  output logic wake_o
);
  logic snz_q;
  assign wake_o   = snz_q & tick & any_down & ~enter;
  assign snooze_o = snz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      snz_q <= 1'b0;
    else if (enter)  snz_q <= 1'b1;
    else if (wake_o) snz_q <= 1'b0;
  end

  // R7: tick with a key down while snoozing returns to awake
  p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snz_q && tick && any_down && !enter |=> !snz_q);
  // R8: no tick means no wake
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snz_q && !tick |=> snz_q);
endmodule

// File: rtl/irq_gen.sv
module irq_gen
  import irq_kbd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] en_i,
  input  logic [7:0] sta_i,
  output logic       irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_wanted(en_i, sta_i);
  end

  // R1: interrupt only after global enable was set
  p_gie_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(en_i[GIE_BIT]));
endmodule

// File: rtl/irq_kbd_wake.sv
module irq_kbd_wake
  import irq_kbd_pkg::*;
#(
  parameter logic [7:0] PORT_CTRL = 8'h40,
  parameter logic [7:0] PORT_ACK  = 8'h41,
  parameter logic [7:0] PORT_KBD  = 8'h42
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [63:0] key_rows,
  input  logic        tick_5ms,
  input  logic        rtc_flag,
  input  logic        evt_pulse,
  input  logic [4:0]  evt_lvl,
  output logic        irq,
  output logic        snooze
);
  logic [7:0] port;
  logic en_wr, ack_wr, sta_rd, kbd_rd;
  logic [7:0] en_q, sta, kdata, ack_bits;
  logic pend1_q, key_q, any_down, wake, enter;

  assign port   = bus_addr[7:0];
  assign en_wr  = bus_wr && (port == PORT_CTRL);
  assign ack_wr = bus_wr && (port == PORT_ACK);
  assign sta_rd = bus_rd && (port == PORT_CTRL);
  assign kbd_rd = bus_rd && (port == PORT_KBD);
  assign ack_bits = bus_wdata & MASKABLE_ACK;
  assign enter  = kbd_rd && en_q[KWAIT_BIT];

  assign sta = {evt_lvl, key_q, pend1_q, rtc_flag};

  kbd_matrix #(.ROWS(ROWS), .COLS(COLS)) u_kbd (
    .rows_n(key_rows), .sel_n(bus_addr[15:8]), .data(kdata), .any_down(any_down));

  snooze_ctl u_snz (
    .clk(clk), .rst_n(rst_n), .enter(enter), .tick(tick_5ms),
    .any_down(any_down), .snooze_o(snooze), .wake_o(wake));

  irq_gen u_irq (.clk(clk), .rst_n(rst_n), .en_i(en_q), .sta_i(sta), .irq_o(irq));

  always_comb begin
    if (sta_rd)      bus_rdata = sta;
    else if (kbd_rd) bus_rdata = kdata;
    else             bus_rdata = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      pend1_q <= 1'b0;
      key_q   <= 1'b0;
    end else begin
      if (en_wr)       en_q <= bus_wdata;
      else if (ack_wr) en_q <= en_q & ~ack_bits;
      if (evt_pulse)   pend1_q <= 1'b1;
      else if (sta_rd) pend1_q <= 1'b0;
      if (wake)        key_q <= 1'b1;
      else if (ack_wr && ack_bits[KEY_STA]) key_q <= 1'b0;
    end
  end

  // R3: acknowledged enable bits are removed
  p_ack_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr && bus_wdata[5] |=> !en_q[5]);
  // R3: bits outside the mask are kept
  p_ack_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> en_q[GIE_BIT] == $past(en_q[GIE_BIT]));
  // R4: status read drops the bit 1 latch
  p_rd_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sta_rd && !evt_pulse |=> !pend1_q);
  // R6: keyboard read with wait enabled enters snooze
  p_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> snooze);
  // R7: wake raises the key flag
  p_keyflag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> key_q);
endmodule

// File: tb/tb_irq_kbd_wake.sv
module tb_irq_kbd_wake;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [63:0] key_rows = '1;
  logic tick_5ms = 0, rtc_flag = 0, evt_pulse = 0;
  logic [4:0] evt_lvl = 0;
  logic irq, snooze;

  int checks = 0, fails = 0;
  logic [7:0] m_en = 0;
  logic m_p1 = 0, m_key = 0, m_snz = 0, m_irq = 0;

  always #2.5 clk = ~clk;

  irq_kbd_wake dut (.*);

  function automatic logic f_irq(logic [7:0] en, logic [7:0] st);
    logic hit = 0;
    for (int b = 2; b < 8; b++) if (en[b] && st[b]) hit = 1;
    if (en[1] && st[0]) hit = 1;
    return en[0] ? hit : 1'b0;
  endfunction

  function automatic logic [7:0] f_kbd(logic [63:0] k, logic [7:0] sel);
    logic [7:0] d = 8'hFF;
    for (int r = 0; r < 8; r++) if (sel[r] == 1'b0) d = d & k[r*8 +: 8];
    return d;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: inputs set after a falling edge
  task automatic cyc();
    logic [7:0] st, p, ack;
    logic anyk, nx_irq, kr;
    #1;
    st = {evt_lvl, m_key, m_p1, rtc_flag};
    p  = bus_addr[7:0];
    if (bus_rd) begin
      if (p == 8'h40)      chk("R4 status read", bus_rdata, st);
      else if (p == 8'h42) chk("R5 key read", bus_rdata, f_kbd(key_rows, bus_addr[15:8]));
      else                 chk("R10 other port", bus_rdata, 8'hFF);
    end
    nx_irq = f_irq(m_en, st);
    anyk = (key_rows != '1);
    kr = bus_rd && p == 8'h42;
    ack = bus_wdata & 8'b0110_1100;
    @(posedge clk); #1;
    m_irq = nx_irq;
    if (evt_pulse) m_p1 = 1;
    else if (bus_rd && p == 8'h40) m_p1 = 0;
    if (kr && m_en[7]) m_snz = 1;
    else if (m_snz && tick_5ms && anyk) begin m_snz = 0; m_key = 1; end
    else if (bus_wr && p == 8'h41 && ack[2]) m_key = 0;
    if (bus_wr && p == 8'h40) m_en = bus_wdata;
    else if (bus_wr && p == 8'h41) m_en = m_en & ~ack;
    chk("R2 irq", irq, m_irq);
    chk("R7 snooze", snooze, m_snz);
    @(negedge clk);
  endtask

  task automatic idle();
    bus_wr = 0; bus_rd = 0; tick_5ms = 0; evt_pulse = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_wr = 1; bus_addr = {8'h00, a}; bus_wdata = d; cyc(); idle();
  endtask

  task automatic rd(logic [15:0] a);
    bus_rd = 1; bus_addr = a; cyc(); idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 irq after reset", irq, 0);
    chk("R9 snooze after reset", snooze, 0);
    rd(16'h0040);
    // R1: source active without global enable
    rtc_flag = 1; wr(8'h40, 8'h02); cyc();
    chk("R1 no irq without gie", irq, 0);
    wr(8'h40, 8'h03); cyc();
    chk("R2 timer irq", irq, 1);
    rtc_flag = 0; cyc(); cyc();
    chk("R2 irq drops", irq, 0);
    // R3: ack masking
    evt_lvl = 5'b00100; wr(8'h40, 8'h21); cyc();
    chk("R3 level irq", irq, 1);
    wr(8'h41, 8'h01); cyc();
    chk("R3 gie kept by ack", irq, 1);
    wr(8'h41, 8'h20); cyc();
    chk("R3 ack removed enable", irq, 0);
    evt_lvl = 0;
    // R4: event latch then read clears
    evt_pulse = 1; cyc(); idle();
    rd(16'h0040); rd(16'h0040);
    // R5: row selects
    key_rows = '1; key_rows[7*8+3] = 0; key_rows[0] = 0;
    rd(16'h7F42); rd(16'hFE42); rd(16'h0042); rd(16'hFF42);
    key_rows = '1;
    // R6/R8/R7: snooze and wake
    wr(8'h40, 8'h85);
    rd(16'h0042);
    chk("R6 snooze entered", snooze, 1);
    tick_5ms = 1; cyc(); idle();
    chk("R8 tick without key", snooze, 1);
    key_rows[20] = 0; cyc();
    chk("R8 key without tick", snooze, 1);
    tick_5ms = 1; cyc(); idle();
    chk("R7 woke", snooze, 0);
    key_rows = '1; cyc();
    chk("R7 key flag irq", irq, 1);
    rd(16'h0040);
    wr(8'h41, 8'h04); cyc();
    chk("R3 key flag cleared", irq, 0);
    rd(16'h0040);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int unsigned k = $urandom_range(0, 9);
      idle();
      rtc_flag = $urandom_range(0, 1);
      evt_lvl = $urandom_range(0, 31) & ($urandom_range(0, 1) ? 5'h1F : 5'h00);
      evt_pulse = ($urandom_range(0, 7) == 0);
      tick_5ms = ($urandom_range(0, 3) == 0);
      key_rows = '1;
      if ($urandom_range(0, 3) == 0) key_rows[$urandom_range(0, 63)] = 0;
      bus_addr = {8'($urandom_range(0, 255)), 8'h40 + 8'($urandom_range(0, 3))};
      bus_wdata = 8'($urandom_range(0, 255));
      if (k < 3) bus_wr = 1;
      else if (k < 7) bus_rd = 1;
      cyc();
    end
    idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule